// File: doc/BRIEF.md
# Multi-Owner Hardware Resource Lock Bank

This block arbitrates ownership of a set of shared resources among several requesters. Each requester has its own ownership register, one bit per resource. It is reached through two word addresses: an acquire address and a release address. Writing a mask to the acquire address claims every listed resource that no other requester currently holds. Writing a mask to the release address gives up the listed resources. Reading either address returns the requester's current ownership mask.

All register traffic runs over one simple bus that carries one operation per cycle. The conflict check for a write therefore always sees the ownership state from before that write, and two requesters can never win the same resource. A sticky software-error interrupt flags misuse: re-acquiring a resource the requester already holds, or releasing one it does not hold. Software clears the interrupt by writing 1 to bit 0 of a dedicated interrupt-clear word.

Word index map with the default 16 requesters: index 2*r is the release register of requester r and index 2*r+1 is its acquire register. Index 32 is the interrupt-clear word, and a read of it returns the interrupt state in bit 0. Every other index is unmapped.

Top module: `lock_bank`

## Requirements
- R1: After reset, every ownership register reads 0 and `irq_sw_err` is 0.
- R2: A write to acquire index 2*r+1 sets, in requester r's register, each bit that is 1 in the data and 0 in every requester's register. The new value is readable on the next operation.
- R3: A requested bit that another requester owns is not granted. The owner's register keeps that bit.
- R4: Bits that are 0 in the write data keep their value in the target register, for both acquire and release writes.
- R5: A write to release index 2*r clears, in requester r's register only, each bit that is 1 in the data. The registers of all other requesters keep their value.
- R6: A read of index 2*r or 2*r+1 returns requester r's ownership mask on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R7: An acquire write whose data includes a bit that the requester already owns sets `irq_sw_err` at the same clock edge. Free bits in that write are still granted.
- R8: A release write whose data includes a bit that the requester does not own sets `irq_sw_err`. A bit owned by another requester stays with that requester.
- R9: `irq_sw_err` stays 1 until a write to index 2*NUM_REQ has data bit 0 set, which clears it at that edge. A write there with bit 0 clear has no effect.
- R10: No resource bit is 1 in more than one requester's register at any time.
- R11: Writes to unmapped indices change no register and leave `irq_sw_err` unchanged. Reads of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_addr | input | ADDR_W (6) | Word index |
| bus_wdata | input | NUM_RES (32) | Write data |
| bus_rdata | output | NUM_RES (32) | Read data, registered |
| irq_sw_err | output | 1 | Sticky misuse interrupt |

## Verification
Every write takes effect at the clock edge that samples it. Ownership and `irq_sw_err` therefore hold their new values one edge after the write. Read data appears one edge after `bus_rd`, so a read-back that follows a write shows that write's result. The bench drives each operation just after a falling edge and holds it for one full clock. It samples `irq_sw_err` and `bus_rdata` at the next falling edge, and compares them there with a model that updates once per operation. Random acquire and release traffic uses sparse masks so that conflicts and misuse occur often. After that traffic, a full read-back of all registers checks that no resource has two owners.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int LK_NUM_REQ = 16;
  localparam int LK_NUM_RES = 32;

  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_REL  = 2'd1,
    AK_ACQ  = 2'd2,
    AK_IRQ  = 2'd3
  } lk_addr_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_ACQ    = 2'd1,
    OP_REL    = 2'd2,
    OP_IRQCLR = 2'd3
  } lk_op_e;
endpackage

// File: rtl/lk_addr_dec.sv
module lk_addr_dec
  import lock_pkg::*;
#(
  parameter int NUM_REQ = LK_NUM_REQ,
  parameter int ADDR_W  = $clog2(2*NUM_REQ+1),
  parameter int REQ_W   = $clog2(NUM_REQ)
) (
  input  logic [ADDR_W-1:0] addr,
  output lk_addr_e          kind,
  output logic [REQ_W-1:0]  req_idx
);
  localparam logic [ADDR_W-1:0] IRQ_IDX = ADDR_W'(2*NUM_REQ);
  localparam logic [ADDR_W-2:0] REQ_LIM = (ADDR_W-1)'(NUM_REQ);

  logic [ADDR_W-2:0] word_req;
  assign word_req = addr[ADDR_W-1:1];
  assign req_idx  = addr[REQ_W:1];

  always_comb begin
    kind = AK_NONE;
    if (addr == IRQ_IDX)
      kind = AK_IRQ;
    else if (word_req < REQ_LIM)
      kind = addr[0] ? AK_ACQ : AK_REL;
  end
endmodule

// File: rtl/lk_owner_bank.sv
module lk_owner_bank
  import lock_pkg::*;
#(
  parameter int NUM_REQ = LK_NUM_REQ,
  parameter int NUM_RES = LK_NUM_RES,
  parameter int REQ_W   = $clog2(NUM_REQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  lk_op_e                     op,
  input  logic [REQ_W-1:0]           req_idx,
  input  logic [NUM_RES-1:0]         wdata,
  output logic [NUM_REQ*NUM_RES-1:0] own_flat,
  output logic [NUM_RES-1:0]         sel_own,
  output logic                       err_evt
);
  logic [NUM_RES-1:0] own_q [NUM_REQ];
  logic [NUM_RES-1:0] all_own;

  function automatic logic [NUM_RES-1:0] f_grant(input logic [NUM_RES-1:0] want,
                                                 input logic [NUM_RES-1:0] taken);
    return want & ~taken;
  endfunction

  function automatic logic f_reacquire(input logic [NUM_RES-1:0] want,
                                       input logic [NUM_RES-1:0] mine);
    return |(want & mine);
  endfunction

  function automatic logic f_bad_release(input logic [NUM_RES-1:0] drop,
                                         input logic [NUM_RES-1:0] mine);
    return |(drop & ~mine);
  endfunction

  always_comb begin
    all_own = '0;
    for (int r = 0; r < NUM_REQ; r++) all_own |= own_q[r];
  end

  assign sel_own = own_q[req_idx];

  assign err_evt = ((op == OP_ACQ) && f_reacquire(wdata, sel_own)) ||
                   ((op == OP_REL) && f_bad_release(wdata, sel_own));

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    logic hit;
    assign hit = (req_idx == REQ_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        own_q[g] <= '0;
      else if (hit && op == OP_ACQ)
        own_q[g] <= own_q[g] | f_grant(wdata, all_own);
      else if (hit && op == OP_REL)
        own_q[g] <= own_q[g] & ~wdata;
    end
    assign own_flat[g*NUM_RES +: NUM_RES] = own_q[g];
  end
endmodule

// File: rtl/lk_err_irq.sv
module lk_err_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic clr_evt,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (err_evt) irq <= 1'b1;
    else if (clr_evt) irq <= 1'b0;
  end
endmodule

// File: rtl/lock_bank.sv
module lock_bank
  import lock_pkg::*;
#(
  parameter int NUM_REQ = LK_NUM_REQ,
  parameter int NUM_RES = LK_NUM_RES,
  localparam int REQ_W  = $clog2(NUM_REQ),
  localparam int ADDR_W = $clog2(2*NUM_REQ+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_RES-1:0] bus_wdata,
  output logic [NUM_RES-1:0] bus_rdata,
  output logic               irq_sw_err
);
  lk_addr_e                   kind;
  logic [REQ_W-1:0]           req_idx;
  lk_op_e                     op;
  logic [NUM_REQ*NUM_RES-1:0] own_flat;
  logic [NUM_RES-1:0]         sel_own;
  logic                       err_evt;
  logic                       irq_clr_evt;
  logic                       own_wr;

  lk_addr_dec #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_dec (
    .addr(bus_addr), .kind(kind), .req_idx(req_idx)
  );

  always_comb begin
    op = OP_NONE;
    if (bus_wr) begin
      case (kind)
        AK_ACQ:  op = OP_ACQ;
        AK_REL:  op = OP_REL;
        AK_IRQ:  op = OP_IRQCLR;
        default: op = OP_NONE;
      endcase
    end
  end

  assign irq_clr_evt = (op == OP_IRQCLR) && bus_wdata[0];
  assign own_wr      = (op == OP_ACQ) || (op == OP_REL);

  lk_owner_bank #(.NUM_REQ(NUM_REQ), .NUM_RES(NUM_RES), .REQ_W(REQ_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .op(op), .req_idx(req_idx), .wdata(bus_wdata),
    .own_flat(own_flat), .sel_own(sel_own), .err_evt(err_evt)
  );

  lk_err_irq u_irq (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .clr_evt(irq_clr_evt),
    .irq(irq_sw_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd) begin
      case (kind)
        AK_ACQ, AK_REL: bus_rdata <= sel_own;
        AK_IRQ:         bus_rdata <= NUM_RES'(irq_sw_err);
        default:        bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lock_bank_chk.sv
module lock_bank_chk #(
  parameter int NUM_REQ = 16,
  parameter int NUM_RES = 32,
  parameter int REQ_W   = $clog2(NUM_REQ)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_REQ*NUM_RES-1:0] own_flat,
  input logic                       err_evt,
  input logic                       irq_clr_evt,
  input logic                       own_wr,
  input logic [REQ_W-1:0]           req_idx,
  input logic                       irq_sw_err
);
  logic [NUM_RES-1:0] multi;
  always_comb begin
    for (int b = 0; b < NUM_RES; b++) begin
      int cnt;
      cnt = 0;
      for (int r = 0; r < NUM_REQ; r++) cnt += int'(own_flat[r*NUM_RES + b]);
      multi[b] = (cnt > 1);
    end
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) multi == '0); // R10
  AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n) err_evt |=> irq_sw_err); // R7
  AST_ERR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n) err_evt |-> own_wr); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (irq_sw_err && !irq_clr_evt) |=> irq_sw_err); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) irq_clr_evt |=> !irq_sw_err); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!irq_sw_err && !err_evt) |=> !irq_sw_err); // R11

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_stab
    AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_wr && req_idx == REQ_W'(g)) |=> $stable(own_flat[g*NUM_RES +: NUM_RES])); // R5
  end
endmodule

bind lock_bank lock_bank_chk #(.NUM_REQ(NUM_REQ), .NUM_RES(NUM_RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .own_flat(own_flat), .err_evt(err_evt),
  .irq_clr_evt(irq_clr_evt), .own_wr(own_wr), .req_idx(req_idx),
  .irq_sw_err(irq_sw_err)
);

// File: tb/tb_lock_bank.sv
module tb_lock_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 16;
  localparam int NRES = 32;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NRES-1:0] bus_wdata = '0;
  logic [NRES-1:0] bus_rdata;
  logic irq_sw_err;

  int n_tests = 0, n_fail = 0;
  logic [NRES-1:0] m_own [NREQ];
  logic m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_bank dut (.*);

  function automatic logic [AW-1:0] a_acq(int r); return AW'(2*r + 1); endfunction
  function automatic logic [AW-1:0] a_rel(int r); return AW'(2*r); endfunction

  task automatic chk(string tag, logic [NRES-1:0] act, logic [NRES-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model: walk the bits one by one
  task automatic model_write(logic [AW-1:0] a, logic [NRES-1:0] d);
    int idx = int'(a);
    if (idx == 2*NREQ) begin
      if (d[0]) m_irq = 1'b0;
    end else if (idx < 2*NREQ) begin
      int r = idx / 2;
      for (int b = 0; b < NRES; b++) begin
        if (!d[b]) continue;
        if (idx % 2 == 1) begin
          bit held = 0;
          if (m_own[r][b]) m_irq = 1'b1;
          for (int q = 0; q < NREQ; q++) if (m_own[q][b]) held = 1;
          if (!held) m_own[r][b] = 1'b1;
        end else begin
          if (!m_own[r][b]) m_irq = 1'b1;
          m_own[r][b] = 1'b0;
        end
      end
    end
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [NRES-1:0] d, string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
    chk({tag, " irq"}, NRES'(irq_sw_err), NRES'(m_irq));
  endtask

  task automatic do_rd(logic [AW-1:0] a, logic [NRES-1:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NREQ; r++) m_own[r] = '0;
    m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", NRES'(irq_sw_err), '0);
    for (int r = 0; r < NREQ; r++) begin
      do_rd(a_acq(r), '0, "R1 acq read");
      do_rd(a_rel(r), '0, "R1 rel read");
    end

    // R2 grant, R6 both addresses
    do_wr(a_acq(3), 32'h0000_00F0, "R2 acq");
    do_rd(a_acq(3), 32'h0000_00F0, "R2 R6 acq addr");
    do_rd(a_rel(3), 32'h0000_00F0, "R6 rel addr");

    // R3 conflict
    do_wr(a_acq(5), 32'h0000_0FF0, "R3 acq");
    do_rd(a_acq(5), 32'h0000_0F00, "R3 partial grant");
    do_rd(a_acq(3), 32'h0000_00F0, "R3 owner kept");

    // R7 re-acquire with one free bit
    do_wr(a_acq(3), 32'h0001_0010, "R7 reacquire");
    chk("R7 irq set", NRES'(irq_sw_err), 32'd1);
    do_rd(a_acq(3), 32'h0001_00F0, "R7 free bit granted");

    // R9 sticky
    do_wr(AW'(2*NREQ), 32'h0000_0000, "R9 clr bit0 low");
    chk("R9 still set", NRES'(irq_sw_err), 32'd1);
    do_rd(AW'(2*NREQ), 32'd1, "R9 status read");
    do_wr(AW'(2*NREQ), 32'h0000_0001, "R9 clr");
    chk("R9 cleared", NRES'(irq_sw_err), 32'd0);

    // R5 R4 release
    do_wr(a_rel(5), 32'h0000_0100, "R5 rel");
    do_rd(a_rel(5), 32'h0000_0E00, "R4 R5 remaining");

    // R8 release of bit owned by someone else
    do_wr(a_rel(5), 32'h0000_0010, "R8 bad rel");
    chk("R8 irq", NRES'(irq_sw_err), 32'd1);
    do_rd(a_acq(3), 32'h0001_00F0, "R8 R5 other kept");
    do_wr(AW'(2*NREQ), 32'h1, "R9 clr again");

    // R11 unmapped
    do_wr(AW'(40), 32'hFFFF_FFFF, "R11 unmapped wr");
    do_rd(AW'(40), '0, "R11 unmapped rd");
    do_rd(a_acq(0), '0, "R11 no change");

    // boundaries: last requester, top bit
    do_wr(a_acq(NREQ-1), 32'h8000_0000, "R2 last req top bit");
    do_rd(a_rel(NREQ-1), 32'h8000_0000, "R2 last req readback");
    do_wr(a_acq(0), 32'hFFFF_FFFF, "R3 grab all");
    do_rd(a_acq(0), m_own[0], "R3 grab all readback");
    do_wr(AW'(2*NREQ), 32'h1, "R9 clr");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom_range(NREQ-1, 0));
      logic [NRES-1:0] d = $urandom() & $urandom() & $urandom();
      int k = int'($urandom_range(9, 0));
      if (k < 4)      do_wr(a_acq(r), d, "R2 R3 R7 rand acq");
      else if (k < 8) do_wr(a_rel(r), d, "R5 R8 rand rel");
      else if (k < 9) do_wr(AW'(2*NREQ), NRES'($urandom_range(1, 0)), "R9 rand clr");
      else            do_wr(AW'($urandom_range(63, 2*NREQ+1)), d, "R11 rand unmapped");
      do_rd(($urandom_range(1, 0) != 0) ? a_acq(r) : a_rel(r), m_own[r], "R4 R6 rand readback");
    end

    // R10 full read-back
    for (int r = 0; r < NREQ; r++) do_rd(a_acq(r), m_own[r], "R10 final readback");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule